// File: doc/BRIEF.md
# Four-slot successive-approximation conversion sequencer

This block is the digital side of an 8-bit successive-approximation A/D converter that serves a set of multiplexed analog inputs. Software reaches it through a small register port: one write port and one combinational read port, both addressed by a 3-bit offset. A write to the control register starts a burst of four conversions. The block selects an input channel, holds a sampling phase, and then drives a trial code to the external DAC/comparator pair, one bit at a time. It collects the eight decisions into a result.

The four results of a burst land in four read-only result slots, always in slot order. In single mode one channel is converted four times. In group mode a bank of four adjacent channels is walked from lowest to highest. When the fourth slot is written, a done flag is raised for software to poll. With the repeat bit set, bursts follow one another without a gap and keep overwriting the slots.

Conversions only run while the converter is powered. After power-up they wait for a settling delay. A start requested before that point waits until the delay has elapsed.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the done flag, repeat, group and channel fields, power enable and all four result slots read as zero, and no conversion runs.
- R2: Power enable is bit 7 of the power register at offset 5, and it reads back in bit 7 with the other bits zero. Writing it to 1 while off starts a SETTLE_CYC-cycle settling count. A start requested while off or settling begins only in the cycle after the count completes. Writing 1 while already on has no effect. Writing 0 stops any running burst and drops any waiting start request.
- R3: The control register is at offset 0 and reads as {done, 0, repeat, group, ch[3:0]} from bit 7 down to bit 0. Every write to it clears done, loads bits 5:0, aborts a running burst and requests a new one. The written value of bit 7 is ignored.
- R4: A burst begins on the first clock edge at which the start request is seen with the converter ready. Each conversion lasts 32 cycles, and result slot k (k = 1..4, read at offset k) is written on the edge 32*k cycles after the burst begins.
- R5: Each conversion begins with trial code 0x80 on dac_code during sampling. At the end of each bit slot the trial bit is cleared if cmp_hi is 1 (DAC above the input), otherwise it is kept, and the next lower bit is set. The eighth decision gives the result, which equals the input level when cmp_hi = (dac_code > input).
- R6: In single mode (group bit 4 = 0), chan_sel equals ch[3:0] throughout the burst, and all four slots hold that channel's conversion.
- R7: In group mode (group bit 4 = 1), ch[1:0] are ignored, and the conversion for slot k uses channel {ch[3:2], k-1}. The lowest channel of the bank goes to slot 1 and the highest to slot 4.
- R8: The done flag rises on the same edge that writes slot 4, and at no other time.
- R9: With repeat (bit 5) at 0 the block goes idle after slot 4. With repeat at 1 the next burst starts immediately and overwrites the slots in the same order.
- R10: Writes to the result offsets 1 to 4 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write offset |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read offset |
| rd_data | output | 8 | Read data (combinational) |
| chan_sel | output | 4 | Analog channel code for the current conversion |
| sample_o | output | 1 | High during the sampling phase of a conversion |
| dac_code | output | 8 | Trial code for the external DAC |
| cmp_hi | input | 1 | Comparator: 1 when the DAC output is above the input |

## Verification
On every cycle, the assertions check several invariants. No conversion runs unless the converter is powered and settled. A control write always leaves done low. Done rises only as the fourth conversion completes, and it leaves a one-shot burst idle. Every sampling phase presents 0x80. The channel moves only at a sampling phase, and only in group mode.

The bench's cycle reference model and scenarios show the behaviours that need the whole history to judge. These are exact result values and the edges at which they appear, the slot order in group mode, and starts held back by settling. The scenarios also cover aborted and restarted bursts, power-down during a burst, and writes that must be ignored.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int SETTLE_CYC = 200,
  parameter int SAMPLE_CYC = 16,
  parameter int BIT_CYC    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  output logic [3:0] chan_sel,
  output logic       sample_o,
  output logic [7:0] dac_code,
  input  logic       cmp_hi
);

  localparam int RW       = 8;
  localparam int CONV_CYC = SAMPLE_CYC + RW * BIT_CYC;
  localparam int CW       = $clog2(CONV_CYC);
  localparam int BW       = $clog2(BIT_CYC + 1);
  localparam int SW       = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] CYC_LAST = CW'(CONV_CYC - 1);
  localparam logic [CW-1:0] CYC_BITS = CW'(SAMPLE_CYC);
  localparam logic [BW-1:0] SUB_LAST = BW'(BIT_CYC - 1);
  localparam logic [SW-1:0] SET_DONE = SW'(SETTLE_CYC);
  localparam logic [2:0] A_CTL = 3'd0;
  localparam logic [2:0] A_PWR = 3'd5;
  localparam logic [RW-1:0] TRIAL0 = {1'b1, {(RW-1){1'b0}}};

  logic          pwr, ready, ccf, scan, mult, pend, busy;
  logic [3:0]    chsel;
  logic [1:0]    idx;
  logic [CW-1:0] cyc;
  logic [BW-1:0] sub;
  logic [SW-1:0] settle;
  logic [RW-1:0] sar, mask, decided;
  logic [RW-1:0] res [4];
  logic          unused_bit;

  wire wr_ctl   = wr_en && wr_addr == A_CTL;
  wire wr_pwr   = wr_en && wr_addr == A_PWR;
  wire in_bits  = cyc >= CYC_BITS;
  wire slot_end = busy && in_bits && sub == SUB_LAST;
  wire conv_end = busy && cyc == CYC_LAST;

  assign unused_bit = wr_data[6];
  assign ready      = pwr && settle == SET_DONE;
  assign decided    = sar & ~(cmp_hi ? mask : '0);
  assign chan_sel   = mult ? {chsel[3:2], idx} : chsel;
  assign sample_o   = busy && !in_bits;
  assign dac_code   = sar;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) settle <= '0;
    else if (!pwr) settle <= '0;
    else if (settle != SET_DONE) settle <= settle + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr <= 1'b0; ccf <= 1'b0; scan <= 1'b0; mult <= 1'b0; chsel <= '0;
      pend <= 1'b0; busy <= 1'b0; idx <= '0; cyc <= '0; sub <= '0;
      sar <= TRIAL0; mask <= TRIAL0;
      for (int i = 0; i < 4; i++) res[i] <= '0;
    end else begin
      if (wr_pwr && !wr_data[7]) begin
        pwr <= 1'b0; busy <= 1'b0; pend <= 1'b0;
      end else if (wr_ctl) begin
        ccf <= 1'b0; scan <= wr_data[5]; mult <= wr_data[4]; chsel <= wr_data[3:0];
        pend <= 1'b1; busy <= 1'b0;
      end else if (pend && ready) begin
        busy <= 1'b1; pend <= 1'b0; idx <= '0; cyc <= '0; sub <= '0;
        sar <= TRIAL0; mask <= TRIAL0;
      end else if (busy) begin
        cyc <= conv_end ? '0 : cyc + 1'b1;
        if (in_bits) sub <= (sub == SUB_LAST) ? '0 : sub + 1'b1;
        if (slot_end) begin
          sar  <= decided | (mask >> 1);
          mask <= mask >> 1;
        end
        if (conv_end) begin
          res[idx] <= decided;
          idx  <= idx + 1'b1;
          sar  <= TRIAL0;
          mask <= TRIAL0;
          sub  <= '0;
          if (idx == 2'd3) begin
            ccf <= 1'b1;
            if (!scan) busy <= 1'b0;
          end
        end
      end
      if (wr_pwr && wr_data[7]) pwr <= 1'b1;
    end
  end

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = {ccf, 1'b0, scan, mult, chsel};
      3'd1:    rd_data = res[0];
      3'd2:    rd_data = res[1];
      3'd3:    rd_data = res[2];
      3'd4:    rd_data = res[3];
      3'd5:    rd_data = {pwr, 7'd0};
      default: rd_data = '0;
    endcase
  end

endmodule

module adc_seq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic       pwr,
  input logic       ready,
  input logic       busy,
  input logic       ccf,
  input logic       scan,
  input logic       mult,
  input logic [1:0] idx,
  input logic [3:0] chan_sel,
  input logic       sample_o,
  input logic [7:0] dac_code
);

  // R2
  settle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ready);

  // R2
  power_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr |-> !busy);

  // R3
  ctl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd0) |=> !ccf);

  // R5
  first_trial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> dac_code == 8'h80);

  // R7
  chan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && chan_sel != $past(chan_sel)) |-> (sample_o && mult));

  // R8
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ccf) |-> ($past(busy) && $past(idx) == 2'd3));

  // R9
  one_shot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ccf) && !scan) |-> !busy);

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (.*);

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
  localparam int CLK_P  = 20;
  localparam int SETTLE = 200;
  localparam int CONV   = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [3:0] chan_sel;
  logic       sample_o;
  logic [7:0] dac_code;
  logic       cmp_hi;
  logic [7:0] ain [16];

  int n_chk = 0;
  int n_err = 0;

  adc_seq_ctrl #(.SETTLE_CYC(SETTLE)) i_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .chan_sel(chan_sel), .sample_o(sample_o),
    .dac_code(dac_code), .cmp_hi(cmp_hi)
  );

  always #(CLK_P / 2) clk = ~clk;
  assign cmp_hi = dac_code > ain[chan_sel];

  // reference model state
  logic       m_pwr = 0, m_ccf = 0, m_scan = 0, m_mult = 0, m_pend = 0, m_busy = 0;
  logic [3:0] m_ch = 0;
  logic [1:0] m_idx = 0;
  int         m_t = 0, m_scnt = 0;
  logic [7:0] m_res [4] = '{default: 8'h00};

  function automatic logic [3:0] exp_chan();
    return m_mult ? {m_ch[3:2], m_idx} : m_ch;
  endfunction

  always @(posedge clk) begin
    logic rdy, w_ctl, w_pwr;
    int   nscnt;
    if (!rst_n) begin
      m_pwr = 0; m_ccf = 0; m_scan = 0; m_mult = 0; m_pend = 0; m_busy = 0;
      m_ch = 0; m_idx = 0; m_t = 0; m_scnt = 0;
      for (int i = 0; i < 4; i++) m_res[i] = 8'h00;
    end else begin
      rdy   = m_pwr && m_scnt == SETTLE;
      w_ctl = wr_en && wr_addr == 3'd0;
      w_pwr = wr_en && wr_addr == 3'd5;
      nscnt = m_scnt;
      if (!m_pwr) nscnt = 0;
      else if (m_scnt < SETTLE) nscnt = m_scnt + 1;
      if (w_pwr && !wr_data[7]) begin
        m_pwr = 0; m_busy = 0; m_pend = 0;
      end else if (w_ctl) begin
        m_ccf = 0; m_scan = wr_data[5]; m_mult = wr_data[4]; m_ch = wr_data[3:0];
        m_pend = 1; m_busy = 0;
      end else if (m_pend && rdy) begin
        m_busy = 1; m_pend = 0; m_t = 0; m_idx = 0;
      end else if (m_busy) begin
        if (m_t == CONV - 1) begin
          m_res[m_idx] = ain[exp_chan()];
          if (m_idx == 2'd3) begin
            m_ccf = 1;
            if (!m_scan) m_busy = 0;
          end
          m_idx = m_idx + 2'd1;
          m_t = 0;
        end else m_t = m_t + 1;
      end
      if (w_pwr && wr_data[7]) m_pwr = 1;
      m_scnt = nscnt;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      for (int a = 0; a < 6; a++) begin
        rd_addr = 3'(a);
        #1;
        case (a)
          0: chk("R3 control/done", rd_data, {m_ccf, 1'b0, m_scan, m_mult, m_ch});
          1: chk("R4 slot1", rd_data, m_res[0]);
          2: chk("R4 slot2", rd_data, m_res[1]);
          3: chk("R4 slot3", rd_data, m_res[2]);
          4: chk("R4 slot4", rd_data, m_res[3]);
          default: chk("R2 power", rd_data, {m_pwr, 7'd0});
        endcase
      end
      if (m_busy) chk("R6/R7 channel", {4'd0, chan_sel}, {4'd0, exp_chan()});
      chk("R5 sampling code", {7'd0, sample_o && dac_code != 8'h80}, 8'd0);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_err++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int i = 0; i < 16; i++) ain[i] = 8'((i * 37 + 11) & 8'hFF);
    ain[4] = 8'h00; ain[5] = 8'hFF; ain[6] = 8'h80; ain[7] = 8'h7F;
    ain[0] = 8'h01; ain[1] = 8'hFE; ain[2] = 8'h55; ain[3] = 8'hAA;
    idle(3);
    rst_n = 1'b1;
    // R1: explicit reset-state read
    @(negedge clk); #7;
    rd_addr = 3'd0; #1; chk("R1 control", rd_data, 8'h00);
    rd_addr = 3'd4; #1; chk("R1 slot4", rd_data, 8'h00);
    // R2: start held while unpowered, then through settling
    wr(3'd0, 8'h05);
    idle(20);
    wr(3'd5, 8'h80);
    idle(100);
    wr(3'd5, 8'hFF);            // R2: already on, no restart of settling
    idle(250);
    // R10: result slots read-only
    wr(3'd2, 8'h33);
    wr(3'd4, 8'hC3);
    idle(3);
    // R3/R7: bit 7 ignored, group 4-7 with low select bits ignored
    wr(3'd0, 8'h97);
    idle(140);
    // R9: repeating group 0-3, then restart mid-burst as single ch3
    wr(3'd0, 8'h30);
    idle(400);
    wr(3'd0, 8'h03);
    idle(140);
    // R2: power-down mid-burst drops the burst and the request
    wr(3'd0, 8'h12);
    idle(50);
    wr(3'd5, 8'h00);
    idle(20);
    wr(3'd5, 8'h80);
    idle(250);
    // R9/R6: repeating single ch6, then switch to ch8 during repeat
    wr(3'd0, 8'h26);
    idle(300);
    wr(3'd0, 8'h08);
    idle(140);
    // R5: new input level while idle, boundary codes
    ain[2] = 8'h01;
    wr(3'd0, 8'h02);
    idle(140);
    ain[12] = 8'hFF; ain[13] = 8'h00; ain[14] = 8'h80; ain[15] = 8'h7F;
    wr(3'd0, 8'h1C);
    idle(140);
    summary();
  end
endmodule